// File: doc/BRIEF.md
# Programmable-Modulus Cycle Counter

This block keeps an 8-bit count that steps once on every bus clock and falls back to zero once it has reached a limit that software chooses at run time. The count sequence therefore has a period of limit + 1. Software reads the count through a small window of read-only word addresses that all mirror the same value. A single writable register holds the limit and can be read back.

The count stays at zero, and every count read returns 0x0000, until software writes the limit register for the first time after reset. From that write on the counter runs freely. Reading the count does not disturb it, and writes to any address other than the limit register have no effect.

Reads go through a registered port. The data for an address presented in one cycle appears on `rd_data` after the next rising edge. It shows the count as it stood just before that edge.

Top module: `cyc_modcount_top`

## Requirements
- R1: While `rst` is high, `rd_data`, the count and the stored limit are all cleared. After reset, a read of the limit address (byte address 0x2C) returns 0x0000 and a read of the count window returns 0x0000.
- R2: Until the limit register has been written after reset, every read of the count window returns 0x0000, even after many cycles and after writes to other addresses.
- R3: Once a limit has been written, the count advances by exactly one on every clock. It does so whether or not it is being read, so two reads taken N cycles apart differ by N modulo (limit + 1).
- R4: After the count equals the low 8 bits of the limit, the next clock sets it to 0, which gives a period of limit + 1. A limit of 0 keeps the count at 0.
- R5: Only bits 7:0 of the limit take part in the wrap. A limit of 0x01FF gives the same sequence as 0x00FF, with a peak of 0xFF.
- R6: Every byte address from 0xA0 to 0xA7 (word addresses 0xA0, 0xA2, 0xA4 and 0xA6) returns the same live count. The count is zero-extended to 16 bits: bits 15:8 are 0.
- R7: A write to any address in the count window changes neither the count nor its step. In particular it does not reset the count.
- R8: A read of address 0x2C returns all 16 bits last written there.
- R9: Writes to addresses other than 0x2C leave the count sequence and the limit unchanged. Reads of addresses outside 0x2C and 0xA0–0xA7 return 0x0000.
- R10: If the limit is written below the current count, the count is 0 after the clock that follows the write's clock. It then steps up from 0 under the new limit.
- R11: `rd_data` is registered. After the rising edge that samples `addr`, it shows the value for that address, with the count taken as it was just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the count steps on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data for the address of the previous cycle |

## Verification
The main function is tried with several read patterns. Back-to-back reads of one address confirm the single-cycle step. Reads spaced 32 cycles apart show that the count runs freely between accesses. A sweep across the four mirror addresses separates true mirroring from an address-dependent offset. Limits of 5, 0, 0x00FF and 0x01FF are used: 5 and 0 show where the wrap occurs, and the last two show that the upper limit bits are dropped. Further tests cover a write into the count window, writes to unrelated addresses, and a limit lowered below the live count. Each of these would show up as a break in the step pattern that the cycle-by-cycle reference model predicts.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  localparam int unsigned ADDR_W_D     = 8;
  localparam int unsigned DATA_W_D     = 16;
  localparam int unsigned CNT_W_D      = 8;
  localparam logic [7:0]  LIMIT_ADDR_D = 8'h2C;
  localparam logic [7:0]  COUNT_BASE_D = 8'hA0;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_COUNT = 2'd2
  } sel_e;
endpackage

// File: rtl/cyc_addr_decode.sv
module cyc_addr_decode
  import cyc_pkg::*;
#(
  parameter int unsigned ADDR_W     = ADDR_W_D,
  parameter logic [ADDR_W-1:0] LIMIT_ADDR = ADDR_W'(LIMIT_ADDR_D),
  parameter logic [ADDR_W-1:0] COUNT_BASE = ADDR_W'(COUNT_BASE_D),
  parameter int unsigned MIRRORS    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  // Each mirror is one 16-bit word, i.e. two byte addresses.
  localparam int unsigned WIN_LSB = $clog2(MIRRORS * 2);

  logic hit_count;
  logic hit_limit;

  assign hit_count = (addr[ADDR_W-1:WIN_LSB] == COUNT_BASE[ADDR_W-1:WIN_LSB]);
  assign hit_limit = (addr == LIMIT_ADDR);

  always_comb begin
    if (hit_count)      sel = SEL_COUNT;
    else if (hit_limit) sel = SEL_LIMIT;
    else                sel = SEL_NONE;
  end
endmodule

// File: rtl/cyc_limit_reg.sv
module cyc_limit_reg
  import cyc_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] lim_q,
  output logic              armed
);
  logic load;
  assign load = wr_en && (sel == SEL_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= '0;
      armed <= 1'b0;
    end else if (load) begin
      lim_q <= wr_data;
      armed <= 1'b1;
    end
  end

  // R8
  lim_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (lim_q == $past(wr_data)) && armed);

  // R9
  lim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(lim_q) && $stable(armed));
endmodule

// File: rtl/cyc_mod_counter.sv
module cyc_mod_counter #(
  parameter int unsigned CNT_W = cyc_pkg::CNT_W_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic [CNT_W-1:0] lim_lo,
  output logic [CNT_W-1:0] cnt_q
);
  logic at_top;
  assign at_top = (cnt_q >= lim_lo);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (armed)  cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (cnt_q < lim_lo)) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R10
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (cnt_q >= lim_lo)) |=> cnt_q == '0);

  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> cnt_q == '0);
endmodule

// File: rtl/cyc_read_mux.sv
module cyc_read_mux
  import cyc_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_D,
  parameter int unsigned CNT_W  = CNT_W_D
) (
  input  logic              clk,
  input  logic              rst,
  input  sel_e              sel,
  input  logic              armed,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [DATA_W-1:0] lim_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] rd_next;

  assign cnt_ext = armed ? {{PAD_W{1'b0}}, cnt_q} : '0;

  always_comb begin
    unique case (sel)
      SEL_COUNT: rd_next = cnt_ext;
      SEL_LIMIT: rd_next = lim_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R6
  mirror_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_COUNT) |=> (rd_data[DATA_W-1:CNT_W] == '0) &&
                           (rd_data[CNT_W-1:0] == ($past(armed) ? $past(cnt_q) : '0)));

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> rd_data == '0);
endmodule

// File: rtl/cyc_modcount_top.sv
module cyc_modcount_top
  import cyc_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_D,
  parameter int unsigned DATA_W  = DATA_W_D,
  parameter int unsigned CNT_W   = CNT_W_D,
  parameter int unsigned MIRRORS = 4,
  parameter logic [ADDR_W-1:0] LIMIT_ADDR = ADDR_W'(LIMIT_ADDR_D),
  parameter logic [ADDR_W-1:0] COUNT_BASE = ADDR_W'(COUNT_BASE_D)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  sel_e              sel;
  logic [DATA_W-1:0] lim_q;
  logic              armed;
  logic [CNT_W-1:0]  cnt_q;

  cyc_addr_decode #(
    .ADDR_W(ADDR_W), .LIMIT_ADDR(LIMIT_ADDR),
    .COUNT_BASE(COUNT_BASE), .MIRRORS(MIRRORS)
  ) u_dec (
    .addr(addr), .sel(sel)
  );

  cyc_limit_reg #(.DATA_W(DATA_W)) u_lim (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel),
    .wr_data(wr_data), .lim_q(lim_q), .armed(armed)
  );

  cyc_mod_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .armed(armed),
    .lim_lo(lim_q[CNT_W-1:0]), .cnt_q(cnt_q)
  );

  cyc_read_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .armed(armed),
    .cnt_q(cnt_q), .lim_q(lim_q), .rd_data(rd_data)
  );

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && (cnt_q == '0) && (lim_q == '0) && !armed);
endmodule

// File: tb/cyc_modcount_tb_top.sv
module cyc_modcount_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_en  = 1'b0;
  bit done    = 1'b0;

  // Behavioural reference model state
  int m_cnt = 0, m_lim = 0, m_rd = 0;
  bit m_arm = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_modcount_top dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_lim = 0; m_arm = 1'b0; m_rd = 0;
    end else begin
      if (addr >= 8'hA0 && addr <= 8'hA7) m_rd = m_arm ? m_cnt : 0;
      else if (addr == 8'h2C)             m_rd = m_lim;
      else                                m_rd = 0;
      if (m_arm) m_cnt = (m_cnt >= (m_lim % 256)) ? 0 : m_cnt + 1;
      if (wr_en && addr == 8'h2C) begin
        m_lim = int'(wr_data); m_arm = 1'b1;
      end
    end
  end

  // R11: registered read data versus the model on every clock
  always @(negedge clk) if (cmp_en) check("R11 per-cycle model", int'(rd_data), m_rd);

  task automatic rd(input logic [7:0] a, output int v);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    addr = 8'h00; wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v, v1, v2, vmax;
    bit seen_wrap;
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", int'(rd_data), 0);
    rst = 1'b0;
    cmp_en = 1'b1;
    rd(8'h2C, v); check("R1 limit after reset", v, 0);
    rd(8'hA0, v); check("R1 count after reset", v, 0);

    // R2: no limit written yet
    idle(40);
    wr(8'h3E, 16'h2000);
    wr(8'hA2, 16'h0055);
    for (int i = 0; i < 4; i++) begin
      rd(8'hA0 + 8'(2*i), v); check("R2 count before limit", v, 0);
    end

    // R8 / R4: limit 5
    wr(8'h2C, 16'h0005);
    rd(8'h2C, v); check("R8 limit readback", v, 5);
    rd(8'hA0, v1); vmax = v1;
    for (int i = 0; i < 12; i++) begin
      rd(8'hA0, v2);
      check("R4 step mod 6", v2, (v1 + 1) % 6);
      if (v2 > vmax) vmax = v2;
      v1 = v2;
    end
    check("R4 peak equals limit", vmax, 5);

    // R4: limit 0 holds count at zero
    wr(8'h2C, 16'h0000);
    idle(2);
    for (int i = 0; i < 4; i++) begin
      rd(8'hA4, v); check("R4 limit zero", v, 0);
    end

    // R3 / R6: limit 0xFF, free-run and mirrors
    wr(8'h2C, 16'h00FF);
    idle(3);
    rd(8'hA0, v1); idle(31); rd(8'hA0, v2);
    check("R3 step over 32 cycles", v2, (v1 + 32) % 256);
    rd(8'hA0, v1);
    for (int i = 1; i < 4; i++) begin
      rd(8'hA0 + 8'(2*i), v2);
      check("R6 mirror step", v2, (v1 + 1) % 256);
      check("R6 upper byte zero", v2 >> 8, 0);
      v1 = v2;
    end
    rd(8'hA5, v2); check("R6 odd byte mirror", v2, (v1 + 1) % 256);

    // R7: write into count window does not reset
    rd(8'hA0, v1); wr(8'hA4, 16'h0000); rd(8'hA0, v2);
    check("R7 count write ignored", v2, (v1 + 2) % 256);

    // R9: unrelated writes and unmapped reads
    rd(8'hA0, v1); wr(8'h74, 16'h1E00); wr(8'h7E, 16'h0015); rd(8'hA0, v2);
    check("R9 unrelated writes", v2, (v1 + 3) % 256);
    rd(8'h2C, v); check("R9 limit unchanged", v, 16'h00FF);
    rd(8'h50, v); check("R9 unmapped read", v, 0);

    // R5: limit 0x1FF acts as 0xFF
    wr(8'h2C, 16'h01FF);
    rd(8'h2C, v); check("R5/R8 full readback", v, 16'h01FF);
    vmax = 0; seen_wrap = 1'b0;
    rd(8'hA6, v1);
    for (int i = 0; i < 300; i++) begin
      rd(8'hA6, v2);
      if (v2 > vmax) vmax = v2;
      if (v1 == 255 && v2 == 0) seen_wrap = 1'b1;
      v1 = v2;
    end
    check("R5 peak 0xFF", vmax, 255);
    check("R5 wrap after 0xFF", int'(seen_wrap), 1);

    // R10: lower limit below live count
    do rd(8'hA0, v); while (v != 199);
    wr(8'h2C, 16'h0010);
    rd(8'hA0, v1); rd(8'hA0, v2); rd(8'hA0, v);
    check("R10 count before wrap", v1, 201);
    check("R10 zero after lowering", v2, 0);
    check("R10 restart", v, 1);

    // R1: reset mid-run clears everything
    rst = 1'b1; cmp_en = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; cmp_en = 1'b1;
    rd(8'hA0, v); check("R1 count after second reset", v, 0);
    rd(8'h2C, v); check("R1 limit after second reset", v, 0);

    cmp_en = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule